// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This core retires one instruction on every rising clock edge. It supports a small subset of a 32-bit load/store instruction set: register add and subtract, OR with a zero-extended immediate, word load, word store, branch on equal and an absolute jump. Instruction storage and data storage are separate word arrays held inside the core. Both arrays read combinationally and write at the clock edge. The same edge updates the program counter and the 32-entry register file. A decoder turns the opcode and function fields into a small set of control strobes. The datapath uses those strobes to pick operands, the extension mode, the ALU operation, the write-back source and the next program counter.

A host fills instruction storage through a word-indexed load port, usually while reset is held. It then releases reset and lets the core run. A debug read port returns any register and any data word. The write-back and store strobes of the instruction now executing appear on the ports, so each retired instruction can be compared against a reference as it completes.

Instruction fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0], jump target [25:0].

Top module: `scpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register becomes 0. Reset is synchronous.
- R2: Opcode 000000 with function 100000 writes rs+rt to rd, and with function 100010 writes rs-rt to rd. The write is reported on `wbEn`/`wbAddr`/`wbData`.
- R3: Opcode 001101 writes rs OR {16'h0, imm} to rt, so the immediate is zero-extended.
- R4: Opcode 100011 loads the data word at byte address rs + sign-extended imm into rt. Opcode 101011 stores rt to that address and writes no register. Data words are indexed by address bits [DA+1:2].
- R5: Opcode 000100 compares rs with rt. When they are equal the next PC is PC+4+(sign-extended imm << 2), otherwise PC+4. It writes neither a register nor memory.
- R6: Opcode 000010 sets the next PC to {PC+4 [31:28], target, 2'b00} and writes nothing.
- R7: Register 0 always reads as zero, and a write aimed at it is dropped (`wbEn` stays low).
- R8: Any other opcode, and any opcode-000000 function other than the two above, writes nothing and advances the PC by 4. All non-control-flow instructions advance the PC by 4.
- R9: A result written at one edge is visible to the very next instruction, which covers back-to-back dependencies through both registers and memory.
- R10: Instruction words written through `imemWe`/`imemAddr` are fetched at PC word index PC[IA+1:2]. The debug ports return register and data word contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imemWe | input | 1 | Instruction storage write strobe |
| imemAddr | input | IA | Instruction word index to write |
| imemData | input | 32 | Instruction word to write |
| dbgRegSel | input | 5 | Register selected for the debug read |
| dbgRegVal | output | 32 | Value of the selected register |
| dbgMemSel | input | DA | Data word index for the debug read |
| dbgMemVal | output | 32 | Value of the selected data word |
| pcOut | output | 32 | Byte address of the instruction now executing |
| wbEn | output | 1 | Register write happens at the coming edge |
| wbAddr | output | 5 | Register being written |
| wbData | output | 32 | Value being written |
| stEn | output | 1 | Data store happens at the coming edge |
| stAddr | output | 32 | Byte address of the store |
| stData | output | 32 | Word being stored |

## Verification
The assertions check the following on every cycle:
- the PC returns to zero after a reset edge;
- a store and a register write never coincide;
- branches never write;
- every non-control-flow instruction advances the PC by exactly 4;
- a jump lands on its target field.

Only the bench's scenario can show the arithmetic results, zero versus sign extension, the taken and not-taken branch decisions (including a backward branch), the load-after-store path through data memory and the dropped writes to register 0. It does this by comparing each retired instruction against an independent instruction-level model and then reading the final register and memory contents.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } aluOp_e;

  typedef struct packed {
    logic   regDst;
    logic   aluSrc;
    logic   extSigned;
    logic   memToReg;
    logic   regWrite;
    logic   memWrite;
    logic   branch;
    logic   jump;
    aluOp_e aluOp;
  } ctrl_t;
endpackage

// File: rtl/scpu_control.sv
module scpu_control
  import scpu_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl
);
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       unusedFields;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign unusedFields = ^instr[25:6];

  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD) begin
          ctrl.regDst   = 1'b1;
          ctrl.regWrite = 1'b1;
          ctrl.aluOp    = ALU_ADD;
        end else if (funct == FN_SUB) begin
          ctrl.regDst   = 1'b1;
          ctrl.regWrite = 1'b1;
          ctrl.aluOp    = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.aluOp    = ALU_OR;
      end
      OP_LW: begin
        ctrl.aluSrc    = 1'b1;
        ctrl.extSigned = 1'b1;
        ctrl.memToReg  = 1'b1;
        ctrl.regWrite  = 1'b1;
      end
      OP_SW: begin
        ctrl.aluSrc    = 1'b1;
        ctrl.extSigned = 1'b1;
        ctrl.memWrite  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.extSigned = 1'b1;
        ctrl.branch    = 1'b1;
        ctrl.aluOp     = ALU_SUB;
      end
      OP_J: begin
        ctrl.jump = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
  parameter int NUM_REGS = 32,
  parameter int WIDTH    = 32,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    raA,
  input  logic [AW-1:0]    raB,
  input  logic [AW-1:0]    raD,
  output logic [WIDTH-1:0] rdA,
  output logic [WIDTH-1:0] rdB,
  output logic [WIDTH-1:0] rdD,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd
);
  logic [WIDTH-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  // Entry zero is held at zero by the write guard; reads also force it.
  assign rdA = (raA == '0) ? '0 : regs[raA];
  assign rdB = (raB == '0) ? '0 : regs[raB];
  assign rdD = (raD == '0) ? '0 : regs[raD];
endmodule

// File: rtl/scpu_datapath.sv
module scpu_datapath
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA = $clog2(IMEM_WORDS),
  localparam int DA = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  input  logic            imemWe,
  input  logic [IA-1:0]   imemAddr,
  input  logic [XLEN-1:0] imemData,
  input  logic [4:0]      dbgRegSel,
  output logic [XLEN-1:0] dbgRegVal,
  input  logic [DA-1:0]   dbgMemSel,
  output logic [XLEN-1:0] dbgMemVal,
  output logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] pcOut,
  output logic            wbEn,
  output logic [4:0]      wbAddr,
  output logic [XLEN-1:0] wbData,
  output logic            stEn,
  output logic [XLEN-1:0] stAddr,
  output logic [XLEN-1:0] stData
);
  logic [XLEN-1:0] pcQ, pcNext, pcPlus4, branchTgt, jumpTgt;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] busA, busB, extImm, opB, aluRes, loadData;
  logic [4:0]      rsIdx, rtIdx, rdIdx;
  logic [15:0]     imm16;
  logic            aluZero;
  logic [DA-1:0]   dIdx;
  logic            unusedBits;

  // Fetch
  assign instr = imem[pcQ[IA+1:2]];

  always_ff @(posedge clk) begin
    if (imemWe) imem[imemAddr] <= imemData;
  end

  // Field split
  assign rsIdx = instr[25:21];
  assign rtIdx = instr[20:16];
  assign rdIdx = instr[15:11];
  assign imm16 = instr[15:0];

  scpu_regfile #(.NUM_REGS(32), .WIDTH(XLEN)) rf_i (
    .clk (clk),
    .rst (rst),
    .raA (rsIdx),
    .raB (rtIdx),
    .raD (dbgRegSel),
    .rdA (busA),
    .rdB (busB),
    .rdD (dbgRegVal),
    .we  (wbEn),
    .wa  (wbAddr),
    .wd  (wbData)
  );

  // Operand select and ALU
  assign extImm = ctrl.extSigned ? {{(XLEN-16){imm16[15]}}, imm16}
                                 : {{(XLEN-16){1'b0}}, imm16};
  assign opB    = ctrl.aluSrc ? extImm : busB;

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_SUB: aluRes = busA - opB;
      ALU_OR:  aluRes = busA | opB;
      default: aluRes = busA + opB;
    endcase
  end
  assign aluZero = (aluRes == '0);

  // Data memory
  assign dIdx     = aluRes[DA+1:2];
  assign loadData = dmem[dIdx];
  assign dbgMemVal = dmem[dbgMemSel];

  always_ff @(posedge clk) begin
    if (stEn) dmem[dIdx] <= busB;
  end

  assign stEn   = ctrl.memWrite && !rst;
  assign stAddr = aluRes;
  assign stData = busB;

  // Write-back
  assign wbAddr = ctrl.regDst ? rdIdx : rtIdx;
  assign wbData = ctrl.memToReg ? loadData : aluRes;
  assign wbEn   = ctrl.regWrite && (wbAddr != 5'd0) && !rst;

  // Next PC
  assign pcPlus4   = pcQ + 32'd4;
  assign branchTgt = pcPlus4 + {extImm[XLEN-3:0], 2'b00};
  assign jumpTgt   = {pcPlus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                  pcNext = jumpTgt;
    else if (ctrl.branch && aluZero) pcNext = branchTgt;
    else                            pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= pcNext;
  end

  assign pcOut = pcQ;
  assign unusedBits = ^{pcQ[1:0], pcQ[XLEN-1:IA+2], aluRes[1:0], aluRes[XLEN-1:DA+2], instr[10:6]};
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA = $clog2(IMEM_WORDS),
  localparam int DA = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imemWe,
  input  logic [IA-1:0]   imemAddr,
  input  logic [31:0]     imemData,
  input  logic [4:0]      dbgRegSel,
  output logic [31:0]     dbgRegVal,
  input  logic [DA-1:0]   dbgMemSel,
  output logic [31:0]     dbgMemVal,
  output logic [31:0]     pcOut,
  output logic            wbEn,
  output logic [4:0]      wbAddr,
  output logic [31:0]     wbData,
  output logic            stEn,
  output logic [31:0]     stAddr,
  output logic [31:0]     stData
);
  ctrl_t           ctrl;
  logic [XLEN-1:0] instr;

  scpu_control ctl_i (
    .instr (instr),
    .ctrl  (ctrl)
  );

  scpu_datapath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .imemWe    (imemWe),
    .imemAddr  (imemAddr),
    .imemData  (imemData),
    .dbgRegSel (dbgRegSel),
    .dbgRegVal (dbgRegVal),
    .dbgMemSel (dbgMemSel),
    .dbgMemVal (dbgMemVal),
    .instr     (instr),
    .pcOut     (pcOut),
    .wbEn      (wbEn),
    .wbAddr    (wbAddr),
    .wbData    (wbData),
    .stEn      (stEn),
    .stAddr    (stAddr),
    .stData    (stData)
  );
endmodule

// File: rtl/scpu_core_checker.sv
module scpu_core_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] pcOut,
  input logic        wbEn,
  input logic        stEn
);
  logic [5:0] opc;
  assign opc = instr[31:26];

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (pcOut == 32'd0));

  assert_store_no_wb_R4: assert property (@(posedge clk) disable iff (rst)
    !(stEn && wbEn));

  assert_branch_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b000100) |-> (!wbEn && !stEn));

  assert_jump_target_R6: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b000010) |=> (pcOut[27:0] == {$past(instr[25:0]), 2'b00}));

  assert_jump_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b000010) |-> (!wbEn && !stEn));

  assert_seq_advance_R8: assert property (@(posedge clk) disable iff (rst)
    ((opc != 6'b000100) && (opc != 6'b000010)) |=> (pcOut == $past(pcOut) + 32'd4));
endmodule

bind scpu_core scpu_core_checker chk_i (
  .clk   (clk),
  .rst   (rst),
  .instr (instr),
  .pcOut (pcOut),
  .wbEn  (wbEn),
  .stEn  (stEn)
);

// File: tb/scpu_core_tb_top.sv
`timescale 1ns/1ps
module scpu_core_tb_top;
  localparam int IW = 64;
  localparam int DW = 64;
  localparam int NCYC = 30;

  typedef struct {
    logic [31:0] pc;
    logic        wbEn;
    logic [4:0]  wbAddr;
    logic [31:0] wbData;
    logic        stEn;
    logic [31:0] stAddr;
    logic [31:0] stData;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imemWe = 1'b0;
  logic [5:0]  imemAddr = '0;
  logic [31:0] imemData = '0;
  logic [4:0]  dbgRegSel = '0;
  logic [31:0] dbgRegVal;
  logic [5:0]  dbgMemSel = '0;
  logic [31:0] dbgMemVal;
  logic [31:0] pcOut, wbData, stAddr, stData;
  logic        wbEn, stEn;
  logic [4:0]  wbAddr;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  logic [31:0] prog [IW];
  logic [31:0] mReg [32];
  logic [31:0] mMem [DW];
  logic [31:0] mPc;
  item_t       expQ [$];

  always #2.5 clk = ~clk;

  scpu_core dut_i (
    .clk(clk), .rst(rst), .imemWe(imemWe), .imemAddr(imemAddr), .imemData(imemData),
    .dbgRegSel(dbgRegSel), .dbgRegVal(dbgRegVal), .dbgMemSel(dbgMemSel), .dbgMemVal(dbgMemVal),
    .pcOut(pcOut), .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData),
    .stEn(stEn), .stAddr(stAddr), .stData(stData)
  );

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: instruction-level model pushes one expected item per cycle
  task automatic driveModel();
    logic [31:0] ins, a, b, sx, zx, ad;
    logic [5:0] op, fn;
    item_t it;
    ins = prog[mPc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    a = (ins[25:21] == 0) ? 32'd0 : mReg[ins[25:21]];
    b = (ins[20:16] == 0) ? 32'd0 : mReg[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'd0, ins[15:0]};
    it.pc = mPc; it.wbEn = 0; it.wbAddr = 0; it.wbData = 0;
    it.stEn = 0; it.stAddr = 0; it.stData = 0; it.tag = "R8";
    mPc = mPc + 4;
    if (op == 6'b000000 && (fn == 6'b100000 || fn == 6'b100010)) begin
      it.tag = "R2"; it.wbAddr = ins[15:11];
      it.wbData = (fn == 6'b100000) ? a + b : a - b;
      it.wbEn = 1;
    end else if (op == 6'b001101) begin
      it.tag = "R3"; it.wbAddr = ins[20:16]; it.wbData = a | zx; it.wbEn = 1;
    end else if (op == 6'b100011) begin
      ad = a + sx;
      it.tag = "R4"; it.wbAddr = ins[20:16]; it.wbData = mMem[ad[7:2]]; it.wbEn = 1;
    end else if (op == 6'b101011) begin
      ad = a + sx;
      it.tag = "R4"; it.stEn = 1; it.stAddr = ad; it.stData = b;
      mMem[ad[7:2]] = b;
    end else if (op == 6'b000100) begin
      it.tag = "R5";
      if (a == b) mPc = mPc + {sx[29:0], 2'b00};
    end else if (op == 6'b000010) begin
      it.tag = "R6"; mPc = {mPc[31:28], ins[25:0], 2'b00};
    end
    if (it.wbEn && it.wbAddr == 0) begin
      it.wbEn = 0; it.wbData = 0; it.tag = "R7";
    end
    if (it.wbEn) mReg[it.wbAddr] = it.wbData;
    if (!it.wbEn) begin it.wbAddr = 0; it.wbData = 0; end
    expQ.push_back(it);
  endtask

  task automatic regCheck(input string req, input int idx, input logic [31:0] exp);
    dbgRegSel = idx[4:0];
    #1;
    check(req, $sformatf("final r%0d", idx), dbgRegVal, exp);
  endtask

  initial begin
    // Program: byte address = 4 * word index
    for (int i = 0; i < IW; i++) prog[i] = 32'd0;
    prog[0]  = encI(6'b001101, 0, 1, 16'h0005);
    prog[1]  = encI(6'b001101, 0, 2, 16'hFFFF);
    prog[2]  = encR(1, 2, 3, 6'b100000);
    prog[3]  = encR(1, 2, 4, 6'b100010);
    prog[4]  = encI(6'b101011, 0, 3, 16'h0008);
    prog[5]  = encI(6'b100011, 0, 5, 16'h0008);
    prog[6]  = encI(6'b001101, 1, 0, 16'h0007);
    prog[7]  = encI(6'b000100, 1, 2, 16'h0005);
    prog[8]  = encI(6'b000100, 5, 3, 16'h0002);
    prog[9]  = encI(6'b001101, 0, 6, 16'h0BAD);
    prog[10] = encI(6'b001101, 0, 6, 16'h0BAD);
    prog[11] = encI(6'b001101, 0, 7, 16'h0020);
    prog[12] = encI(6'b101011, 7, 4, 16'hFFFC);
    prog[13] = encI(6'b100011, 7, 8, 16'hFFFC);
    prog[14] = {6'b111111, 5'd1, 5'd9, 16'h1234};
    prog[15] = {6'b000010, 26'd17};
    prog[16] = encI(6'b001101, 0, 9, 16'h0BAD);
    prog[17] = encI(6'b000100, 0, 0, 16'hFFFF);

    for (int i = 0; i < 32; i++) mReg[i] = 0;
    for (int i = 0; i < DW; i++) mMem[i] = 'x;
    mPc = 0;

    // Load instruction storage under reset
    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      imemWe = 1'b1; imemAddr = i[5:0]; imemData = prog[i];
    end
    @(negedge clk);
    imemWe = 1'b0;
    #1;
    check("R1", "pc in reset", pcOut, 32'd0);
    dbgRegSel = 5'd1; #1;
    check("R1", "r1 in reset", dbgRegVal, 32'd0);
    check("R10", "first fetched word drives no store", {31'd0, stEn}, 32'd0);

    for (int i = 0; i < NCYC; i++) driveModel();

    @(negedge clk);
    rst = 1'b0;
    // Monitor: pop and compare once per cycle
    for (int c = 0; c < NCYC; c++) begin
      item_t e;
      #1;
      e = expQ.pop_front();
      check(e.tag, $sformatf("cycle %0d pc", c), pcOut, e.pc);
      check(e.tag, $sformatf("cycle %0d wbEn", c), {31'd0, wbEn}, {31'd0, e.wbEn});
      if (e.wbEn) begin
        check(e.tag, $sformatf("cycle %0d wbAddr", c), {27'd0, wbAddr}, {27'd0, e.wbAddr});
        check(e.tag, $sformatf("cycle %0d wbData", c), wbData, e.wbData);
      end
      check(e.tag, $sformatf("cycle %0d stEn", c), {31'd0, stEn}, {31'd0, e.stEn});
      if (e.stEn) begin
        check(e.tag, $sformatf("cycle %0d stAddr", c), stAddr, e.stAddr);
        check(e.tag, $sformatf("cycle %0d stData", c), stData, e.stData);
      end
      @(negedge clk);
    end

    // Final state, fixed values worked out from the requirements
    regCheck("R7", 0, 32'd0);
    regCheck("R3", 1, 32'h0000_0005);
    regCheck("R3", 2, 32'h0000_FFFF);
    regCheck("R2", 3, 32'h0001_0004);
    regCheck("R2", 4, 32'hFFFF_0006);
    regCheck("R9", 5, 32'h0001_0004);
    regCheck("R5", 6, 32'd0);
    regCheck("R4", 7, 32'h0000_0020);
    regCheck("R4", 8, 32'hFFFF_0006);
    regCheck("R8", 9, 32'd0);
    dbgMemSel = 6'd2; #1;
    check("R4", "mem word 2", dbgMemVal, 32'h0001_0004);
    dbgMemSel = 6'd7; #1;
    check("R4", "mem word 7", dbgMemVal, 32'hFFFF_0006);
    check("R5", "backward branch holds pc", pcOut, 32'd68);

    // Reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "pc after second reset", pcOut, 32'd0);
    regCheck("R1", 3, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule